// File: doc/BRIEF.md
# Return Address Stack

This block keeps subroutine return addresses for a small processor whose data registers are only 8 bits wide, too narrow to hold an instruction address. Instead of one link register, the processor sees a last-in, first-out store: writing the link destination pushes an address, and reading the link source pops the most recent one. A call pushes the address of the instruction after the call. A return pops the saved address and uses it as the next fetch address.

A register-indirect call jumps through the saved address and leaves a fresh return address in its place. It asserts push and pop in the same cycle. The block then hands out the current top and overwrites that slot with the new address, so the depth stays the same.

The top entry is driven combinationally from the stored state. A pop therefore delivers its address in the cycle it is requested. Overflow and underflow never corrupt stored entries. Each raises a sticky flag that only reset clears.

Top module: `return_addr_stack`

## Requirements
- R1: While rst_n is low at a rising clock edge, the stack is emptied and both sticky flags are cleared. After that edge, level reads 0, empty reads 1, full reads 0 and top_addr reads 0.
- R2: With push_en high, pop_en low and the stack not full, the edge stores push_addr as the new top. After that edge, top_addr equals push_addr and level is one higher.
- R3: top_addr always shows the most recently stored entry that has not been removed, including in the cycle where pop_en is high. With pop_en high, push_en low and the stack not empty, the edge removes that entry and lowers level by one. Entries come back in the reverse of their storage order.
- R4: With push_en and pop_en both high and the stack not empty, the top entry is replaced by push_addr and level is unchanged. The entry below it is left intact.
- R5: With push_en high and pop_en low while full, the push is discarded: level and every stored entry stay the same, and overflow reads 1 after the edge.
- R6: With pop_en high and push_en low while empty, top_addr reads 0, level stays 0, and underflow reads 1 after the edge.
- R7: With push_en and pop_en both high while empty, the pop part underflows: top_addr reads 0 in that cycle and underflow reads 1 after the edge. The push part still completes, so level becomes 1 and top_addr equals push_addr.
- R8: With push_en and pop_en both high while full, the top is replaced, level stays at DEPTH, and overflow does not change.
- R9: empty is 1 exactly when level is 0. full is 1 exactly when level equals DEPTH (16 by default).
- R10: Once overflow or underflow reads 1, it stays 1 until reset, whatever push and pop requests follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| push_en | input | 1 | Store push_addr on top (link write) |
| push_addr | input | AW (10) | Return address to store |
| pop_en | input | 1 | Remove the top entry (link read) |
| top_addr | output | AW (10) | Current top entry; 0 when empty |
| level | output | LW (5) | Number of stored entries |
| full | output | 1 | level equals DEPTH |
| empty | output | 1 | level is zero |
| overflow | output | 1 | Sticky: a push was discarded while full |
| underflow | output | 1 | Sticky: a pop was requested while empty |

## Verification
The flags, level, full, empty, and the top after a push or swap all come from state updated at one clock edge. Each is valid one cycle after its request. top_addr on a pop is combinational and is correct in the request cycle itself, before the edge. The bench applies requests at the falling edge, reads the popped address shortly after applying it, and reads all registered results just after the following rising edge. Because the bench samples at those points, a design that delays the top by a cycle or updates state early is caught.

// File: rtl/ras_pkg.sv
// Package: shared types for the return address stack.
// Assumes the request encoding {push, pop} maps directly onto ras_op_e.
package ras_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_SWAP = 2'b11
    } ras_op_e;
endpackage

// File: rtl/ras_ctrl.sv
// Module: ras_ctrl
// Holds the occupancy count and turns push/pop requests into a write
// strobe, a write slot, a read slot and overflow/underflow events.
// Assumes DEPTH >= 2 and IW = clog2(DEPTH), LW = clog2(DEPTH+1).
module ras_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IW    = 4,
    parameter int LW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic          pop_en,
    output logic [LW-1:0] level,
    output logic          is_full,
    output logic          is_empty,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [IW-1:0] rd_idx,
    output logic          ovf_evt,
    output logic          udf_evt
);
    localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);
    localparam logic [LW-1:0] LVL_ONE = LW'(1);

    ras_op_e       op;
    logic [LW-1:0] level_nxt;
    logic [LW-1:0] top_pos;

    assign is_full  = (level == LVL_MAX);
    assign is_empty = (level == '0);
    assign top_pos  = level - LVL_ONE;
    assign op       = ras_op_e'({push_en, pop_en});

    // Purpose: select the read slot of the current top entry.
    always_comb begin
        rd_idx = is_empty ? '0 : IW'(top_pos);
    end

    // Purpose: decode the request into a write, a new level and error events.
    always_comb begin
        wr_en     = 1'b0;
        wr_idx    = IW'(level);
        level_nxt = level;
        ovf_evt   = 1'b0;
        udf_evt   = 1'b0;
        unique case (op)
            OP_PUSH: begin
                if (is_full) begin
                    ovf_evt = 1'b1;
                end else begin
                    wr_en     = 1'b1;
                    wr_idx    = IW'(level);
                    level_nxt = level + LVL_ONE;
                end
            end
            OP_POP: begin
                if (is_empty) begin
                    udf_evt = 1'b1;
                end else begin
                    level_nxt = top_pos;
                end
            end
            OP_SWAP: begin
                wr_en = 1'b1;
                if (is_empty) begin
                    udf_evt   = 1'b1;
                    wr_idx    = '0;
                    level_nxt = LVL_ONE;
                end else begin
                    wr_idx = IW'(top_pos);
                end
            end
            default: begin
                level_nxt = level;
            end
        endcase
    end

    // Purpose: occupancy register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            level <= level_nxt;
        end
    end
endmodule

// File: rtl/ras_store.sv
// Module: ras_store
// Register array of DEPTH entries, one write port and one asynchronous
// read port. Entries are not reset; the owner masks reads while empty.
module ras_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 10,
    parameter int IW    = 4
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_data
);
    logic [AW-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Purpose: load this slot when it is the selected write target.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IW'(g))) begin
                slot[g] <= wr_data;
            end
        end
    end

    // Purpose: combinational read of the selected slot.
    always_comb begin
        rd_data = slot[rd_idx];
    end
endmodule

// File: rtl/ras_flags.sv
// Module: ras_flags
// Sticky overflow and underflow indicators, cleared only by reset.
module ras_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_evt,
    input  logic udf_evt,
    output logic overflow,
    output logic underflow
);
    // Purpose: latch each error event until the next reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            overflow  <= overflow  | ovf_evt;
            underflow <= underflow | udf_evt;
        end
    end
endmodule

// File: rtl/return_addr_stack.sv
// Module: return_addr_stack
// LIFO of instruction addresses acting as the link register: push on
// link write, pop on link read, pop-then-push in one cycle for an
// indirect call. Top output is combinational and reads 0 when empty.
// Assumes callers never depend on the contents of removed entries.
module return_addr_stack #(
    parameter int DEPTH = 16,
    parameter int AW    = 10,
    localparam int IW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic [AW-1:0] push_addr,
    input  logic          pop_en,
    output logic [AW-1:0] top_addr,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          overflow,
    output logic          underflow
);
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] rd_idx;
    logic [AW-1:0] rd_data;
    logic          ovf_evt;
    logic          udf_evt;

    ras_ctrl #(.DEPTH(DEPTH), .IW(IW), .LW(LW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (push_en),
        .pop_en   (pop_en),
        .level    (level),
        .is_full  (full),
        .is_empty (empty),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .ovf_evt  (ovf_evt),
        .udf_evt  (udf_evt)
    );

    ras_store #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (push_addr),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    ras_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf_evt   (ovf_evt),
        .udf_evt   (udf_evt),
        .overflow  (overflow),
        .underflow (underflow)
    );

    // Purpose: present the top entry, forcing 0 while nothing is stored.
    always_comb begin
        top_addr = empty ? '0 : rd_data;
    end
endmodule

// File: rtl/return_addr_stack_chk.sv
// Module: return_addr_stack_chk
// Port-level temporal checks for return_addr_stack, attached by bind.
module return_addr_stack_chk #(
    parameter int DEPTH = 16,
    parameter int AW    = 10,
    parameter int LW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_en,
    input logic [AW-1:0] push_addr,
    input logic          pop_en,
    input logic [AW-1:0] top_addr,
    input logic [LW-1:0] level,
    input logic          full,
    input logic          empty,
    input logic          overflow,
    input logic          underflow
);
    assert_push_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !pop_en && !full) |=>
            (top_addr == $past(push_addr)) && (level == $past(level) + LW'(1)));

    assert_pop_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !push_en && !empty) |=> (level == $past(level) - LW'(1)));

    assert_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && pop_en && !empty) |=>
            $stable(level) && (top_addr == $past(push_addr)));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !pop_en && full) |=> $stable(level) && $stable(top_addr) && overflow);

    assert_empty_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (top_addr == '0));

    assert_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && empty) |=> underflow);

    assert_swap_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && pop_en && empty) |=> (level == LW'(1)) && !empty);

    assert_swap_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && pop_en && full && !overflow) |=> !overflow && full);

    assert_full_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_sticky_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_sticky_udf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);
endmodule

bind return_addr_stack return_addr_stack_chk #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_en),
    .push_addr (push_addr),
    .pop_en    (pop_en),
    .top_addr  (top_addr),
    .level     (level),
    .full      (full),
    .empty     (empty),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/test_return_addr_stack.sv
// Bench: directed scenarios for return_addr_stack, one task each.
module test_return_addr_stack;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int AW         = 10;
    localparam int LW         = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_en = 1'b0;
    logic [AW-1:0] push_addr = '0;
    logic          pop_en = 1'b0;
    logic [AW-1:0] top_addr;
    logic [LW-1:0] level;
    logic          full;
    logic          empty;
    logic          overflow;
    logic          underflow;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    return_addr_stack #(.DEPTH(DEPTH), .AW(AW)) i_return_addr_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_addr (push_addr),
        .pop_en    (pop_en),
        .top_addr  (top_addr),
        .level     (level),
        .full      (full),
        .empty     (empty),
        .overflow  (overflow),
        .underflow (underflow)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // One clock with the given request; returns just after the edge.
    task automatic step(input logic p, input logic [AW-1:0] a, input logic q);
        @(negedge clk);
        push_en = p; push_addr = a; pop_en = q;
        @(posedge clk);
        #1;
        push_en = 1'b0; pop_en = 1'b0;
        #1;
    endtask

    // Pop, checking the combinational top inside the request cycle.
    task automatic pop_expect(input string req, input int expected);
        @(negedge clk);
        pop_en = 1'b1;
        #1;
        check(req, int'(top_addr), expected);
        @(posedge clk);
        #1;
        pop_en = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; push_en = 1'b0; pop_en = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    function automatic logic [AW-1:0] fill_val(input int i);
        return AW'(i * 37 + 5);
    endfunction

    task automatic t_reset();
        do_reset();
        check("R1 level", int'(level), 0);
        check("R1 empty", int'(empty), 1);
        check("R1 top", int'(top_addr), 0);
        check("R1 overflow", int'(overflow), 0);
        check("R1 underflow", int'(underflow), 0);
        check("R9 full at reset", int'(full), 0);
    endtask

    task automatic t_push_pop();
        do_reset();
        step(1'b1, 10'h101, 1'b0);
        check("R2 top", int'(top_addr), 'h101);
        step(1'b1, 10'h2A5, 1'b0);
        step(1'b1, 10'h3FF, 1'b0);
        check("R2 level", int'(level), 3);
        check("R2 top", int'(top_addr), 'h3FF);
        check("R9 empty clear", int'(empty), 0);
        pop_expect("R3 pop top", 'h3FF);
        check("R3 level", int'(level), 2);
        pop_expect("R3 pop order", 'h2A5);
        pop_expect("R3 pop order", 'h101);
        check("R3 level empty", int'(level), 0);
        check("R9 empty set", int'(empty), 1);
    endtask

    task automatic t_swap();
        do_reset();
        step(1'b1, 10'h011, 1'b0);
        step(1'b1, 10'h022, 1'b0);
        step(1'b1, 10'h033, 1'b1);
        check("R4 swap top", int'(top_addr), 'h033);
        check("R4 swap level", int'(level), 2);
        pop_expect("R4 swap pop", 'h033);
        check("R4 below intact", int'(top_addr), 'h011);
    endtask

    task automatic t_full_overflow();
        do_reset();
        for (int i = 0; i < DEPTH; i++) step(1'b1, fill_val(i), 1'b0);
        check("R9 full", int'(full), 1);
        check("R9 level", int'(level), DEPTH);
        check("R8 no overflow yet", int'(overflow), 0);
        step(1'b1, 10'h2C3, 1'b1);
        check("R8 swap full top", int'(top_addr), 'h2C3);
        check("R8 swap full level", int'(level), DEPTH);
        check("R8 swap full no overflow", int'(overflow), 0);
        step(1'b1, 10'h155, 1'b0);
        check("R5 overflow", int'(overflow), 1);
        check("R5 level", int'(level), DEPTH);
        check("R5 top kept", int'(top_addr), 'h2C3);
        pop_expect("R5 contents kept", 'h2C3);
        for (int i = DEPTH - 2; i >= 0; i--) pop_expect("R3 drain", int'(fill_val(i)));
        check("R9 empty after drain", int'(empty), 1);
        check("R10 overflow sticky", int'(overflow), 1);
    endtask

    task automatic t_underflow();
        do_reset();
        pop_expect("R6 empty top", 0);
        check("R6 underflow", int'(underflow), 1);
        check("R6 level", int'(level), 0);
        check("R6 overflow clear", int'(overflow), 0);
        step(1'b1, 10'h0AA, 1'b0);
        pop_expect("R2 push after underflow", 'h0AA);
        check("R10 underflow sticky", int'(underflow), 1);
    endtask

    task automatic t_swap_empty();
        do_reset();
        @(negedge clk);
        push_en = 1'b1; push_addr = 10'h1E7; pop_en = 1'b1;
        #1;
        check("R7 top in cycle", int'(top_addr), 0);
        @(posedge clk);
        #1;
        push_en = 1'b0; pop_en = 1'b0;
        #1;
        check("R7 underflow", int'(underflow), 1);
        check("R7 level", int'(level), 1);
        check("R7 top", int'(top_addr), 'h1E7);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_push_pop();
        t_swap();
        t_full_overflow();
        t_underflow();
        t_swap_empty();
        finished = 1'b1;
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end
endmodule